// File: doc/BRIEF.md
# Zero-Copy Buffer Ownership Switch

This block keeps track of who may use each buffer in a pool of eight equal RAM buffers. Every buffer belongs at any moment to one of two domains: the packet engine side or the I/O side. Data never moves between the domains. A side hands a buffer to its peer by flipping one ownership bit, and the change counts from the next clock edge. The RAM arrays themselves are kept outside this block.

Each of four endpoints owns a ring of one, two, three or four consecutive buffers, set by a base buffer index and a depth. Within a ring each side keeps its own index and steps through the buffers in strict round-robin order. A side issues a commit when it has finished with its current buffer. If that buffer is still held by the peer, the commit is refused and a stall flag is raised. Per endpoint, the block reports the buffer each side is working on and whether that side currently owns it. It also gives one flat vector with the owner of every buffer in the pool.

The ring configuration is taken from the inputs only while the endpoint is disabled. Disabling an endpoint puts its ring back into the direction's start state. In an OUT endpoint (direction 0) the packet side starts with every buffer. In an IN endpoint (direction 1) the I/O side starts with every buffer.

Top module: `zc_buf_switch`

## Requirements
- R1: After reset, and in any cycle where an endpoint's enable is low, every buffer in that endpoint's ring is owned by the packet side when `ep_dir_i` is 0 and by the I/O side when it is 1. Both side indices of that endpoint are 0.
- R2: Each side's buffer output for endpoint e equals (base + that side's index) modulo 8. Endpoint e's fields sit at bits [3e+2:3e] of the base and buffer vectors and at bits [2e+1:2e] of the depth vector.
- R3: An accepted commit passes the side's current buffer to the peer. In `own_o`, bit b is 1 when the I/O side owns buffer b. The new value appears after the clock edge that samples the commit.
- R4: An accepted commit advances that side's index by one. The index wraps to 0 after slot `depth`. The depth code is 0, 1, 2 or 3, meaning a ring of 1, 2, 3 or 4 buffers.
- R5: A commit whose current buffer is owned by the peer changes no ownership and no index. The side's stall output is 1 for exactly the cycle after the commit is sampled. An accepted commit, or no commit, leaves the stall output at 0 in that cycle.
- R6: A commit to a disabled endpoint is refused with a stall and has no effect on ownership.
- R7: The packet side and the I/O side may commit to the same endpoint in the same cycle, and both are served.
- R8: While an endpoint is enabled, changes on its base and depth inputs are ignored. Disabling it returns its ring to the R1 start state built from the current inputs.
- R9: A buffer that lies in no endpoint's ring is reported as owned by the packet side (own bit 0).
- R10: A side's ready output for endpoint e is 1 exactly when that side owns the buffer its index names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ep_en_i | input | 4 | Endpoint enable, one bit per endpoint |
| ep_dir_i | input | 4 | Endpoint direction, 0 = OUT, 1 = IN |
| ep_base_i | input | 12 | First buffer of each ring, 3 bits per endpoint |
| ep_depth_i | input | 8 | Ring depth code (buffers minus one), 2 bits per endpoint |
| pkt_commit_i | input | 1 | Packet side hands over its current buffer |
| pkt_ep_i | input | 2 | Endpoint of the packet-side commit |
| io_commit_i | input | 1 | I/O side hands over its current buffer |
| io_ep_i | input | 2 | Endpoint of the I/O-side commit |
| pkt_buf_o | output | 12 | Packet side's current buffer per endpoint |
| io_buf_o | output | 12 | I/O side's current buffer per endpoint |
| pkt_ready_o | output | 4 | Packet side owns its current buffer |
| io_ready_o | output | 4 | I/O side owns its current buffer |
| pkt_stall_o | output | 1 | Packet-side commit was refused last cycle |
| io_stall_o | output | 1 | I/O-side commit was refused last cycle |
| own_o | output | 8 | Owner per buffer, 1 = I/O side |

## Verification
Ownership, index and stall results from a commit are due one cycle after the commit is sampled. The bench drives each commit before a rising edge and reads `own_o`, the buffer outputs and the stall flags at the following falling edge. The start state of a disabled endpoint depends on nothing but its inputs. It is therefore checked in the same cycle, one time step after the enable or configuration inputs change. Each table row is applied for exactly one edge, so every expected value depends only on the rows before it.

// File: rtl/zc_buf_pkg.sv
package zc_buf_pkg;
  localparam logic OWN_PKT = 1'b0;
  localparam logic OWN_IO  = 1'b1;
  localparam logic DIR_OUT = 1'b0;
  localparam logic DIR_IN  = 1'b1;
endpackage

// File: rtl/zc_ring.sv
module zc_ring
  import zc_buf_pkg::*;
#(
  parameter int NUM_BUF  = 8,
  parameter int MAX_RING = 4,
  localparam int BUF_W   = $clog2(NUM_BUF),
  localparam int SLOT_W  = $clog2(MAX_RING)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               dir_i,
  input  logic [BUF_W-1:0]   base_i,
  input  logic [SLOT_W-1:0]  depth_i,
  input  logic               pkt_hit_i,
  input  logic               io_hit_i,
  output logic [BUF_W-1:0]   pkt_buf_o,
  output logic [BUF_W-1:0]   io_buf_o,
  output logic               pkt_ready_o,
  output logic               io_ready_o,
  output logic               pkt_refuse_o,
  output logic               io_refuse_o,
  output logic [NUM_BUF-1:0] io_mask_o
);

  logic                en_q;
  logic                dir_q;
  logic [BUF_W-1:0]    base_q;
  logic [SLOT_W-1:0]   depth_q;
  logic [MAX_RING-1:0] slot_io_q;
  logic [SLOT_W-1:0]   pkt_idx_q, io_idx_q;

  logic                live;
  logic                dir_e;
  logic [BUF_W-1:0]    base_e;
  logic [SLOT_W-1:0]   depth_e;
  logic [MAX_RING-1:0] slot_io_e, slot_io_n;
  logic [SLOT_W-1:0]   pkt_idx_e, io_idx_e, pkt_idx_n, io_idx_n;
  logic                pkt_acc, io_acc;

  function automatic logic [SLOT_W-1:0] step_idx(input logic [SLOT_W-1:0] idx,
                                                 input logic [SLOT_W-1:0] last);
    return (idx == last) ? '0 : idx + 1'b1;
  endfunction

  // registered state is valid only from the second enabled cycle on
  assign live      = en_i & en_q;
  assign dir_e     = live ? dir_q     : dir_i;
  assign base_e    = live ? base_q    : base_i;
  assign depth_e   = live ? depth_q   : depth_i;
  assign slot_io_e = live ? slot_io_q : {MAX_RING{(dir_i == DIR_IN) ? OWN_IO : OWN_PKT}};
  assign pkt_idx_e = live ? pkt_idx_q : '0;
  assign io_idx_e  = live ? io_idx_q  : '0;

  assign pkt_ready_o = (slot_io_e[pkt_idx_e] == OWN_PKT);
  assign io_ready_o  = (slot_io_e[io_idx_e]  == OWN_IO);

  assign pkt_acc      = pkt_hit_i & en_i & pkt_ready_o;
  assign io_acc       = io_hit_i  & en_i & io_ready_o;
  assign pkt_refuse_o = pkt_hit_i & ~pkt_acc;
  assign io_refuse_o  = io_hit_i  & ~io_acc;

  assign pkt_buf_o = base_e + BUF_W'(pkt_idx_e);
  assign io_buf_o  = base_e + BUF_W'(io_idx_e);

  always_comb begin
    slot_io_n = slot_io_e;
    pkt_idx_n = pkt_idx_e;
    io_idx_n  = io_idx_e;
    if (pkt_acc) begin
      slot_io_n[pkt_idx_e] = OWN_IO;
      pkt_idx_n            = step_idx(pkt_idx_e, depth_e);
    end
    if (io_acc) begin
      slot_io_n[io_idx_e] = OWN_PKT;
      io_idx_n            = step_idx(io_idx_e, depth_e);
    end
  end

  always_comb begin
    io_mask_o = '0;
    for (int s = 0; s < MAX_RING; s++) begin
      if (SLOT_W'(s) <= depth_e && slot_io_e[s] == OWN_IO)
        io_mask_o[base_e + BUF_W'(s)] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      dir_q     <= DIR_OUT;
      base_q    <= '0;
      depth_q   <= '0;
      slot_io_q <= '0;
      pkt_idx_q <= '0;
      io_idx_q  <= '0;
    end else begin
      en_q      <= en_i;
      dir_q     <= dir_e;
      base_q    <= base_e;
      depth_q   <= depth_e;
      slot_io_q <= slot_io_n;
      pkt_idx_q <= pkt_idx_n;
      io_idx_q  <= io_idx_n;
    end
  end

endmodule

// File: rtl/zc_side_ctl.sv
module zc_side_ctl #(
  parameter int NUM_EP = 4,
  localparam int EP_W  = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [EP_W-1:0]   ep_i,
  input  logic [NUM_EP-1:0] refuse_i,
  output logic [NUM_EP-1:0] hit_o,
  output logic              stall_o
);

  always_comb begin
    hit_o = '0;
    if (commit_i) hit_o[ep_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_o <= 1'b0;
    else         stall_o <= |refuse_i;
  end

endmodule

// File: rtl/zc_own_map.sv
module zc_own_map #(
  parameter int NUM_BUF = 8,
  parameter int NUM_EP  = 4
) (
  input  logic [NUM_EP*NUM_BUF-1:0] io_mask_i,
  output logic [NUM_BUF-1:0]        own_o
);

  always_comb begin
    own_o = '0;
    for (int e = 0; e < NUM_EP; e++) own_o |= io_mask_i[e*NUM_BUF +: NUM_BUF];
  end

endmodule

// File: rtl/zc_buf_switch.sv
module zc_buf_switch #(
  parameter int NUM_BUF  = 8,
  parameter int NUM_EP   = 4,
  parameter int MAX_RING = 4,
  localparam int BUF_W   = $clog2(NUM_BUF),
  localparam int EP_W    = $clog2(NUM_EP),
  localparam int SLOT_W  = $clog2(MAX_RING)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_EP-1:0]       ep_en_i,
  input  logic [NUM_EP-1:0]       ep_dir_i,
  input  logic [NUM_EP*BUF_W-1:0] ep_base_i,
  input  logic [NUM_EP*SLOT_W-1:0] ep_depth_i,
  input  logic                    pkt_commit_i,
  input  logic [EP_W-1:0]         pkt_ep_i,
  input  logic                    io_commit_i,
  input  logic [EP_W-1:0]         io_ep_i,
  output logic [NUM_EP*BUF_W-1:0] pkt_buf_o,
  output logic [NUM_EP*BUF_W-1:0] io_buf_o,
  output logic [NUM_EP-1:0]       pkt_ready_o,
  output logic [NUM_EP-1:0]       io_ready_o,
  output logic                    pkt_stall_o,
  output logic                    io_stall_o,
  output logic [NUM_BUF-1:0]      own_o
);

  logic [NUM_EP-1:0]         pkt_hit, io_hit, pkt_refuse, io_refuse;
  logic [NUM_EP*NUM_BUF-1:0] io_mask;

  zc_side_ctl #(.NUM_EP(NUM_EP)) i_pkt_ctl (
    .clk_i, .rst_ni,
    .commit_i (pkt_commit_i),
    .ep_i     (pkt_ep_i),
    .refuse_i (pkt_refuse),
    .hit_o    (pkt_hit),
    .stall_o  (pkt_stall_o)
  );

  zc_side_ctl #(.NUM_EP(NUM_EP)) i_io_ctl (
    .clk_i, .rst_ni,
    .commit_i (io_commit_i),
    .ep_i     (io_ep_i),
    .refuse_i (io_refuse),
    .hit_o    (io_hit),
    .stall_o  (io_stall_o)
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    zc_ring #(.NUM_BUF(NUM_BUF), .MAX_RING(MAX_RING)) i_ring (
      .clk_i, .rst_ni,
      .en_i         (ep_en_i[e]),
      .dir_i        (ep_dir_i[e]),
      .base_i       (ep_base_i[e*BUF_W +: BUF_W]),
      .depth_i      (ep_depth_i[e*SLOT_W +: SLOT_W]),
      .pkt_hit_i    (pkt_hit[e]),
      .io_hit_i     (io_hit[e]),
      .pkt_buf_o    (pkt_buf_o[e*BUF_W +: BUF_W]),
      .io_buf_o     (io_buf_o[e*BUF_W +: BUF_W]),
      .pkt_ready_o  (pkt_ready_o[e]),
      .io_ready_o   (io_ready_o[e]),
      .pkt_refuse_o (pkt_refuse[e]),
      .io_refuse_o  (io_refuse[e]),
      .io_mask_o    (io_mask[e*NUM_BUF +: NUM_BUF])
    );
  end

  zc_own_map #(.NUM_BUF(NUM_BUF), .NUM_EP(NUM_EP)) i_own_map (
    .io_mask_i (io_mask),
    .own_o     (own_o)
  );

endmodule

// File: rtl/zc_buf_switch_chk.sv
module zc_buf_switch_chk #(
  parameter int NUM_BUF  = 8,
  parameter int NUM_EP   = 4,
  localparam int BUF_W   = $clog2(NUM_BUF),
  localparam int EP_W    = $clog2(NUM_EP)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_EP-1:0]       ep_en_i,
  input logic [NUM_EP-1:0]       ep_dir_i,
  input logic                    pkt_commit_i,
  input logic [EP_W-1:0]         pkt_ep_i,
  input logic                    io_commit_i,
  input logic [EP_W-1:0]         io_ep_i,
  input logic [NUM_EP*BUF_W-1:0] pkt_buf_o,
  input logic [NUM_EP*BUF_W-1:0] io_buf_o,
  input logic [NUM_EP-1:0]       pkt_ready_o,
  input logic [NUM_EP-1:0]       io_ready_o,
  input logic                    pkt_stall_o,
  input logic                    io_stall_o,
  input logic [NUM_BUF-1:0]      own_o
);

  logic [BUF_W-1:0] pkt_cur, io_cur;
  logic             pkt_ok, io_ok;
  assign pkt_cur = pkt_buf_o[pkt_ep_i*BUF_W +: BUF_W];
  assign io_cur  = io_buf_o[io_ep_i*BUF_W +: BUF_W];
  assign pkt_ok  = pkt_commit_i && ep_en_i[pkt_ep_i] && pkt_ready_o[pkt_ep_i];
  assign io_ok   = io_commit_i && ep_en_i[io_ep_i] && io_ready_o[io_ep_i];

  // R5
  pkt_refuse_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_commit_i && !pkt_ready_o[pkt_ep_i] |=> pkt_stall_o);
  // R5
  io_refuse_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_commit_i && !io_ready_o[io_ep_i] |=> io_stall_o);
  // R6
  pkt_disabled_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_commit_i && !ep_en_i[pkt_ep_i] |=> pkt_stall_o);
  // R6
  io_disabled_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_commit_i && !ep_en_i[io_ep_i] |=> io_stall_o);
  // R5
  pkt_no_false_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pkt_commit_i || pkt_ok) |=> !pkt_stall_o);
  // R5
  io_no_false_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_commit_i || io_ok) |=> !io_stall_o);
  // R3
  pkt_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_ok |=> (!ep_en_i[$past(pkt_ep_i)] || own_o[$past(pkt_cur)]));
  // R3
  io_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ok |=> (!ep_en_i[$past(io_ep_i)] || !own_o[$past(io_cur)]));

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep_chk
    // R1
    idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ep_en_i[e] |-> (pkt_ready_o[e] == !ep_dir_i[e]) && (io_ready_o[e] == ep_dir_i[e]));
  end

endmodule

bind zc_buf_switch zc_buf_switch_chk #(.NUM_BUF(NUM_BUF), .NUM_EP(NUM_EP)) i_chk (
  .clk_i, .rst_ni, .ep_en_i, .ep_dir_i, .pkt_commit_i, .pkt_ep_i, .io_commit_i, .io_ep_i,
  .pkt_buf_o, .io_buf_o, .pkt_ready_o, .io_ready_o, .pkt_stall_o, .io_stall_o, .own_o
);

// File: tb/test_zc_buf_switch.sv
`timescale 1ns/1ps
module test_zc_buf_switch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ep_en = 4'hF;
  logic [3:0]  ep_dir = 4'b1010;
  logic [11:0] ep_base = {3'd6, 3'd5, 3'd2, 3'd0};
  logic [7:0]  ep_depth = {2'd1, 2'd0, 2'd2, 2'd1};
  logic        pkt_commit = 1'b0, io_commit = 1'b0;
  logic [1:0]  pkt_ep = '0, io_ep = '0;
  logic [11:0] pkt_buf, io_buf;
  logic [3:0]  pkt_ready, io_ready;
  logic        pkt_stall, io_stall;
  logic [7:0]  own;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zc_buf_switch i_zc_buf_switch (
    .clk_i(clk), .rst_ni(rst_n), .ep_en_i(ep_en), .ep_dir_i(ep_dir),
    .ep_base_i(ep_base), .ep_depth_i(ep_depth),
    .pkt_commit_i(pkt_commit), .pkt_ep_i(pkt_ep),
    .io_commit_i(io_commit), .io_ep_i(io_ep),
    .pkt_buf_o(pkt_buf), .io_buf_o(io_buf),
    .pkt_ready_o(pkt_ready), .io_ready_o(io_ready),
    .pkt_stall_o(pkt_stall), .io_stall_o(io_stall), .own_o(own)
  );

  // pc, pe, ic, ie, exp pkt stall, exp io stall, exp own, exp pkt_buf[pe], exp io_buf[ie]
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hDD, 3'd1, 3'd0},
    {1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hDF, 3'd0, 3'd0},
    {1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 8'hDF, 3'd0, 3'd0},
    {1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 8'hDE, 3'd0, 3'd1},
    {1'b1, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 8'hDD, 3'd1, 3'd0},
    {1'b0, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 8'hD9, 3'd2, 3'd3},
    {1'b0, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 8'hD1, 3'd2, 3'd4},
    {1'b0, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 8'hC1, 3'd2, 3'd2},
    {1'b0, 2'd1, 1'b1, 2'd1, 1'b0, 1'b1, 8'hC1, 3'd2, 3'd2},
    {1'b1, 2'd1, 1'b0, 2'd1, 1'b0, 1'b0, 8'hC5, 3'd3, 3'd2},
    {1'b1, 2'd2, 1'b0, 2'd2, 1'b0, 1'b0, 8'hE5, 3'd5, 3'd5},
    {1'b1, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 8'hE5, 3'd5, 3'd5},
    {1'b0, 2'd2, 1'b1, 2'd2, 1'b0, 1'b0, 8'hC5, 3'd5, 3'd5},
    {1'b1, 2'd3, 1'b0, 2'd3, 1'b1, 1'b0, 8'hC5, 3'd6, 3'd6},
    {1'b1, 2'd2, 1'b1, 2'd3, 1'b0, 1'b0, 8'hA5, 3'd5, 3'd7},
    {1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5, 3'd1, 3'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, one rising edge, sample at next falling edge
  task automatic step(input bit pc, input logic [1:0] pe, input bit ic, input logic [1:0] ie);
    pkt_commit = pc; pkt_ep = pe; io_commit = ic; io_ep = ie;
    @(posedge clk);
    @(negedge clk);
    pkt_commit = 1'b0; io_commit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 start state, ring enabled straight out of reset
    chk("R1", "own", own, 8'hDC);
    chk("R10", "pkt_ready", pkt_ready, 4'b0101);
    chk("R10", "io_ready", io_ready, 4'b1010);
    chk("R2", "pkt_buf", pkt_buf, {3'd6, 3'd5, 3'd2, 3'd0});
    chk("R2", "io_buf", io_buf, {3'd6, 3'd5, 3'd2, 3'd0});
    chk("R5", "stalls", {pkt_stall, io_stall}, 0);

    // R3 R4 R5 R7 table walk
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      step(v[21], v[20:19], v[18], v[17:16]);
      chk("R5", $sformatf("pkt_stall row %0d", i), pkt_stall, v[15]);
      chk("R5", $sformatf("io_stall row %0d", i), io_stall, v[14]);
      chk("R3", $sformatf("own row %0d", i), own, v[13:6]);
      chk("R4", $sformatf("pkt_buf row %0d", i), pkt_buf[v[20:19]*3 +: 3], v[5:3]);
      chk("R2", $sformatf("io_buf row %0d", i), io_buf[v[17:16]*3 +: 3], v[2:0]);
    end

    // R8 config change ignored while enabled
    ep_base[2:0] = 3'd3; ep_depth[1:0] = 2'd3;
    step(1'b0, 2'd0, 1'b0, 2'd0);
    chk("R8", "pkt_buf0 held", pkt_buf[2:0], 1);
    chk("R8", "own held", own, 8'hA5);
    step(1'b1, 2'd0, 1'b0, 2'd0);
    chk("R8", "own after commit", own, 8'hA7);
    chk("R4", "ep0 wraps at old depth", pkt_buf[2:0], 0);
    ep_base[2:0] = 3'd0; ep_depth[1:0] = 2'd1;

    // R8 disable returns ring to start state at once
    ep_en[0] = 1'b0;
    #1;
    chk("R8", "own ep0 reinit", own, 8'hA4);
    chk("R8", "ready ep0 reinit", {pkt_ready[0], io_ready[0]}, 2'b10);
    @(negedge clk);
    // R6 commit to disabled endpoint
    step(1'b1, 2'd0, 1'b0, 2'd0);
    chk("R6", "pkt_stall disabled", pkt_stall, 1);
    chk("R6", "own unchanged", own, 8'hA4);
    ep_en[0] = 1'b1;

    // R9 shrink ep3 to one buffer, buffer 7 falls outside every ring
    ep_en[3] = 1'b0; ep_depth[7:6] = 2'd0;
    #1;
    chk("R9", "own uncovered", own, 8'h64);
    chk("R1", "ep3 io_ready", io_ready[3], 1);
    @(negedge clk);
    ep_en[3] = 1'b1;
    step(1'b0, 2'd0, 1'b1, 2'd3);
    chk("R3", "own ep3 handover", own, 8'h24);
    chk("R4", "depth 1 stays", io_buf[11:9], 6);
    chk("R10", "io_ready ep3", io_ready[3], 0);
    step(1'b0, 2'd0, 1'b1, 2'd3);
    chk("R5", "io_stall ep3", io_stall, 1);
    step(1'b0, 2'd0, 1'b0, 2'd0);
    chk("R5", "stall one cycle", io_stall, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule